// File: doc/BRIEF.md
# Slotted Ring Spike Transmitter

This block is the sending half of one node on a one-way, time-slotted broadcast ring that carries neural spike events. A packet moves one hop per clock, so it takes R clocks to go all the way round. A node may add a packet only once per rotation. The block keeps its own copy of the rotation counter, and that counter marks one cycle in every R as the insert slot. On every other cycle the node copies the packet it receives from the previous node straight into its output register.

Each of the sixteen spike inputs has a stamp register. A spike on an input records the current value of a free-running operating-cycle counter, which runs through sixteen rotations, together with a valid flag. A round-robin pointer visits one input per insert slot. The packet it builds carries the flag, the stamp and the input number. Every destination on the ring can then replay the spike at a fixed offset from the cycle in which it occurred, whatever the path length.

Top module: `ring_spike_tx`

## Requirements
- R1: A synchronous reset clears every stamp register, the rotation counter, the stamp counter and the round-robin pointer, and sets the output packet to all zeros (invalid).
- R2: The rotation count outputs 0,1,..,R-1 and then wraps (R = 8), starting at 0 in the first cycle after reset. The insert indication is high exactly when the count is 0.
- R3: A clock edge taken in a cycle whose rotation count is not 0 loads the output register with the packet present on the ring input in that cycle, unchanged.
- R4: A 7-bit stamp counter starts at 0 in the first cycle after reset and goes up by one each clock, wrapping from 127 to 0. A spike on input x stores the counter value of the cycle in which the spike is high.
- R5: The n-th insert slot after reset (n = 0,1,..) carries input number n mod 16.
- R6: The packet is 12 bits: bit 11 is the valid flag, bits 10..4 are the stamp and bits 3..0 are the input number.
- R7: An insert slot whose selected input holds a pending spike emits a packet with valid 1 and the stored stamp. Sending clears the entry, so the next visit to that input emits valid 0 unless a new spike arrived in between.
- R8: An insert slot whose selected input holds no pending spike emits a packet with valid 0 and that input's number.
- R9: A second spike on an input that still holds an unsent spike replaces the stored stamp. Only the later stamp is ever sent.
- R10: A spike that arrives on the input being sent in that same insert cycle does not affect the packet leaving in that cycle. It is stored as a pending spike with the current stamp and is sent at that input's next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| spike_i | input | 16 | One spike line per source input |
| ring_pkt_i | input | 12 | Packet arriving from the previous node |
| ring_pkt_o | output | 12 | Registered packet to the next node |
| rot_cnt_o | output | 3 | Local rotation count |
| insert_o | output | 1 | High in the insert slot of each rotation |

## Verification
Two actions can fall in the same clock edge: the stamp bank capturing a fresh spike, and the insert slot sending and clearing the same input's register. The bench provokes this by raising input 4 in the exact cycle in which the pointer selects input 4, while an older spike is still pending there. The packet that leaves in that slot must carry the old stamp. One full operating cycle later, the packet for input 4 must carry the stamp of the colliding cycle with its valid flag set, which shows that the capture won over the clear.

// File: rtl/ring_tx_pkg.sv
package ring_tx_pkg;

   typedef enum logic {
      PH_FORWARD = 1'b0,
      PH_INSERT  = 1'b1
   } ring_phase_e;

   function automatic int safe_clog2(input int value);
      return (value > 1) ? $clog2(value) : 1;
   endfunction

endpackage

// File: rtl/ring_phase_gen.sv
module ring_phase_gen
   import ring_tx_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int INPUTS = 16,
   localparam int ROT_W  = safe_clog2(NODES),
   localparam int PERIOD = NODES * INPUTS,
   localparam int TS_W   = safe_clog2(PERIOD)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [ROT_W-1:0] rot_o,
   output ring_phase_e      phase_o,
   output logic [TS_W-1:0]  stamp_o
);

   logic [ROT_W-1:0] rot_q;
   logic [TS_W-1:0]  ts_q;

   // Rotation counter: natural wrap when the ring size is a power of two.
   generate
      if ((NODES & (NODES - 1)) == 0) begin : g_rot_wrap
         always_ff @(posedge clk_i) begin
            if (rst_i) rot_q <= '0;
            else       rot_q <= rot_q + 1'b1;
         end
      end else begin : g_rot_cmp
         always_ff @(posedge clk_i) begin
            if (rst_i)                             rot_q <= '0;
            else if (rot_q == ROT_W'(NODES - 1))   rot_q <= '0;
            else                                   rot_q <= rot_q + 1'b1;
         end
      end
   endgenerate

   // Operating-cycle stamp counter, one full period is INPUTS rotations.
   generate
      if ((PERIOD & (PERIOD - 1)) == 0) begin : g_ts_wrap
         always_ff @(posedge clk_i) begin
            if (rst_i) ts_q <= '0;
            else       ts_q <= ts_q + 1'b1;
         end
      end else begin : g_ts_cmp
         always_ff @(posedge clk_i) begin
            if (rst_i)                             ts_q <= '0;
            else if (ts_q == TS_W'(PERIOD - 1))    ts_q <= '0;
            else                                   ts_q <= ts_q + 1'b1;
         end
      end
   endgenerate

   assign rot_o   = rot_q;
   assign stamp_o = ts_q;
   assign phase_o = (rot_q == '0) ? PH_INSERT : PH_FORWARD;

endmodule

// File: rtl/spike_stamp_bank.sv
module spike_stamp_bank
   import ring_tx_pkg::*;
#(
   parameter int INPUTS = 16,
   parameter int TS_W   = 7,
   localparam int SEL_W = safe_clog2(INPUTS)
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic [INPUTS-1:0]            spike_i,
   input  logic [TS_W-1:0]              stamp_i,
   input  logic                         take_i,
   input  logic [SEL_W-1:0]             take_idx_i,
   output logic [INPUTS-1:0]            vld_o,
   output logic [INPUTS-1:0][TS_W-1:0]  stamp_o
);

   generate
      for (genvar gi = 0; gi < INPUTS; gi++) begin : g_entry
         logic            v_q;
         logic [TS_W-1:0] s_q;
         logic            taken;

         assign taken = take_i && (take_idx_i == SEL_W'(gi));

         // A fresh spike outranks the clear caused by sending this entry.
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               v_q <= 1'b0;
               s_q <= '0;
            end else if (spike_i[gi]) begin
               v_q <= 1'b1;
               s_q <= stamp_i;
            end else if (taken) begin
               v_q <= 1'b0;
            end
         end

         assign vld_o[gi]   = v_q;
         assign stamp_o[gi] = s_q;
      end
   endgenerate

endmodule

// File: rtl/rr_slot_select.sv
module rr_slot_select
   import ring_tx_pkg::*;
#(
   parameter int INPUTS = 16,
   parameter int TS_W   = 7,
   localparam int SEL_W = safe_clog2(INPUTS)
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         advance_i,
   input  logic [INPUTS-1:0]            vld_i,
   input  logic [INPUTS-1:0][TS_W-1:0]  stamp_i,
   output logic [SEL_W-1:0]             sel_o,
   output logic                         pick_vld_o,
   output logic [TS_W-1:0]              pick_stamp_o
);

   logic [SEL_W-1:0] sel_q;

   generate
      if ((INPUTS & (INPUTS - 1)) == 0) begin : g_sel_wrap
         always_ff @(posedge clk_i) begin
            if (rst_i)          sel_q <= '0;
            else if (advance_i) sel_q <= sel_q + 1'b1;
         end
      end else begin : g_sel_cmp
         always_ff @(posedge clk_i) begin
            if (rst_i) sel_q <= '0;
            else if (advance_i) begin
               if (sel_q == SEL_W'(INPUTS - 1)) sel_q <= '0;
               else                             sel_q <= sel_q + 1'b1;
            end
         end
      end
   endgenerate

   assign sel_o        = sel_q;
   assign pick_vld_o   = vld_i[sel_q];
   assign pick_stamp_o = stamp_i[sel_q];

endmodule

// File: rtl/ring_spike_tx.sv
module ring_spike_tx
   import ring_tx_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int INPUTS = 16,
   localparam int ROT_W = safe_clog2(NODES),
   localparam int TS_W  = safe_clog2(NODES * INPUTS),
   localparam int SEL_W = safe_clog2(INPUTS),
   localparam int PKT_W = 1 + TS_W + SEL_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [INPUTS-1:0] spike_i,
   input  logic [PKT_W-1:0]  ring_pkt_i,
   output logic [PKT_W-1:0]  ring_pkt_o,
   output logic [ROT_W-1:0]  rot_cnt_o,
   output logic              insert_o
);

   generate
      if (NODES < 2) begin : g_bad_nodes
         $error("ring_spike_tx: NODES must be at least 2");
      end
      if (INPUTS < 2) begin : g_bad_inputs
         $error("ring_spike_tx: INPUTS must be at least 2");
      end
   endgenerate

   ring_phase_e                 phase;
   logic [TS_W-1:0]             now_stamp;
   logic                        ins;
   logic [INPUTS-1:0]           bank_vld;
   logic [INPUTS-1:0][TS_W-1:0] bank_stamp;
   logic [SEL_W-1:0]            sel;
   logic                        pick_vld;
   logic [TS_W-1:0]             pick_stamp;
   logic [PKT_W-1:0]            local_pkt;
   logic [PKT_W-1:0]            pkt_q;

   ring_phase_gen #(
      .NODES  (NODES),
      .INPUTS (INPUTS)
   ) u_phase (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .rot_o   (rot_cnt_o),
      .phase_o (phase),
      .stamp_o (now_stamp)
   );

   assign ins = (phase == PH_INSERT);

   spike_stamp_bank #(
      .INPUTS (INPUTS),
      .TS_W   (TS_W)
   ) u_bank (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .spike_i    (spike_i),
      .stamp_i    (now_stamp),
      .take_i     (ins),
      .take_idx_i (sel),
      .vld_o      (bank_vld),
      .stamp_o    (bank_stamp)
   );

   rr_slot_select #(
      .INPUTS (INPUTS),
      .TS_W   (TS_W)
   ) u_sel (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .advance_i    (ins),
      .vld_i        (bank_vld),
      .stamp_i      (bank_stamp),
      .sel_o        (sel),
      .pick_vld_o   (pick_vld),
      .pick_stamp_o (pick_stamp)
   );

   // Field order: valid on top, stamp in the middle, input number at the bottom.
   assign local_pkt = {pick_vld, pick_stamp, sel};

   always_ff @(posedge clk_i) begin
      if (rst_i)    pkt_q <= '0;
      else if (ins) pkt_q <= local_pkt;
      else          pkt_q <= ring_pkt_i;
   end

   assign ring_pkt_o = pkt_q;
   assign insert_o   = ins;

endmodule

// File: rtl/ring_spike_tx_chk.sv
module ring_spike_tx_chk
   import ring_tx_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int INPUTS = 16,
   localparam int ROT_W = safe_clog2(NODES),
   localparam int TS_W  = safe_clog2(NODES * INPUTS),
   localparam int SEL_W = safe_clog2(INPUTS),
   localparam int PKT_W = 1 + TS_W + SEL_W
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [PKT_W-1:0]  ring_pkt_i,
   input logic [PKT_W-1:0]  ring_pkt_o,
   input logic [ROT_W-1:0]  rot_cnt_o,
   input logic              insert_o
);

   logic [SEL_W-1:0] slot_seen_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)         slot_seen_q <= '0;
      else if (insert_o) slot_seen_q <= slot_seen_q + 1'b1;
   end

   AST_RESET_INVALID: assert property (@(posedge clk_i)
      rst_i |=> (ring_pkt_o == '0)); // R1

   AST_INSERT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
      (rot_cnt_o == ROT_W'(NODES - 1)) |=> insert_o); // R2

   AST_SINGLE_INSERT: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_o |=> !insert_o); // R2

   AST_FORWARD_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
      !insert_o |=> (ring_pkt_o == $past(ring_pkt_i))); // R3

   AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_o |=> (ring_pkt_o[SEL_W-1:0] == $past(slot_seen_q))); // R5

endmodule

bind ring_spike_tx ring_spike_tx_chk #(
   .NODES  (NODES),
   .INPUTS (INPUTS)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .ring_pkt_i (ring_pkt_i),
   .ring_pkt_o (ring_pkt_o),
   .rot_cnt_o  (rot_cnt_o),
   .insert_o   (insert_o)
);

// File: tb/test_ring_spike_tx.sv
`timescale 1ns/1ps
module test_ring_spike_tx;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] spk = '0;
   logic [11:0] pin = '0;
   logic [11:0] pout;
   logic [2:0]  rot;
   logic        ins;

   int n_chk  = 0;
   int n_fail = 0;
   int k      = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ring_spike_tx i_ring_spike_tx (
      .clk_i      (clk),
      .rst_i      (rst),
      .spike_i    (spk),
      .ring_pkt_i (pin),
      .ring_pkt_o (pout),
      .rot_cnt_o  (rot),
      .insert_o   (ins)
   );

   function automatic logic [11:0] mkpkt(input logic v, input int ts, input int num);
      return {v, 7'(ts), 4'(num)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, k, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      k++;
   endtask

   task automatic goto_cycle(input int t);
      while (k < t) tick();
   endtask

   task automatic spike_now(input int x);
      spk[x] = 1'b1;
      tick();
      spk[x] = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      spk = '0;
      pin = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset packet", 32'(pout), 32'h0);
      chk("R1 reset rotation", 32'(rot), 32'h0);
      rst = 1'b0;
      k   = 0;
   endtask

   // R2, R5, R8: phase sequence and round-robin order over more than one period.
   task automatic t_phase_and_order();
      do_reset();
      for (int c = 0; c < 150; c++) begin
         chk("R2 insert flag", 32'(ins), 32'((k % 8) == 0));
         chk("R2 rotation count", 32'(rot), 32'(k % 8));
         if (k >= 1 && ((k - 1) % 8) == 0)
            chk("R5 R8 empty slot packet", 32'(pout), 32'(mkpkt(1'b0, 0, ((k - 1) / 8) % 16)));
         tick();
      end
   endtask

   // R3: forwarding of ring traffic on non-insert cycles.
   task automatic t_forward();
      do_reset();
      for (int c = 0; c < 40; c++) begin
         pin = 12'(12'hA53 ^ (c * 29));
         tick();
         if (((k - 1) % 8) != 0)
            chk("R3 forward copy", 32'(pout), 32'(12'(12'hA53 ^ ((k - 1) * 29))));
         else
            chk("R3 insert overrides ring input", 32'(pout[11]), 32'h0);
      end
      pin = '0;
   endtask

   // R4, R6, R7, R8: stamping, packet fields, clear after send, counter wrap.
   task automatic t_send();
      do_reset();
      goto_cycle(10);
      spike_now(5);
      goto_cycle(25);
      chk("R8 idle input 3", 32'(pout), 32'(mkpkt(1'b0, 0, 3)));
      goto_cycle(41);
      chk("R6 R7 sent input 5", 32'(pout), 32'(mkpkt(1'b1, 10, 5)));
      goto_cycle(130);
      spike_now(2);
      goto_cycle(145);
      chk("R4 wrapped stamp input 2", 32'(pout), 32'(mkpkt(1'b1, 2, 2)));
      goto_cycle(169);
      chk("R7 cleared after send", 32'(pout[11]), 32'h0);
      chk("R7 number on cleared", 32'(pout[3:0]), 32'h5);
   endtask

   // R9: later spike replaces the pending one.
   task automatic t_overwrite();
      do_reset();
      goto_cycle(20);
      spike_now(7);
      goto_cycle(50);
      spike_now(7);
      goto_cycle(57);
      chk("R9 later stamp wins", 32'(pout), 32'(mkpkt(1'b1, 50, 7)));
   endtask

   // R10: spike on the input being sent in the same insert cycle.
   task automatic t_collide();
      do_reset();
      goto_cycle(1);
      spike_now(4);
      goto_cycle(32);
      chk("R10 insert slot for input 4", 32'(ins), 32'h1);
      spike_now(4);
      chk("R10 old spike sent", 32'(pout), 32'(mkpkt(1'b1, 1, 4)));
      goto_cycle(161);
      chk("R10 colliding spike kept", 32'(pout), 32'(mkpkt(1'b1, 32, 4)));
   endtask

   initial begin
      t_phase_and_order();
      t_forward();
      t_send();
      t_overwrite();
      t_collide();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d: actual hung expected done", k);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule